// File: doc/BRIEF.md
# Single-bit Boolean Processor Unit

This unit executes the one-bit instructions of a small 8-bit microcontroller. A carry flag serves as the accumulator. Each operation arrives already decoded, as a 5-bit operation code with an 8-bit direct bit address, a signed 8-bit branch displacement and the address of the next instruction. The unit reads and writes single bits through a bit-granular memory port. It updates the carry, decides whether a branch is taken and returns the resulting program counter. It also reports how many machine cycles the operation occupies. One machine cycle is one clock cycle here.

A one-cycle `start` strobe launches an operation. The carry update, the branch outcome, the new program counter and any bit write-back all appear together with the `done` pulse. The external memory commits a bit write at the clock edge that closes the `done` cycle. The carry is held inside the unit, but it also answers to its own direct bit address (bit 7 of the status byte at D0h, bit address D7h). A bit operation aimed at that address therefore acts on the carry, and nothing goes out on the memory port.

Top module: `bool_unit`

## Requirements
- R1: The codes 6 (carry AND bit), 7 (carry AND NOT bit), 8 (carry OR bit) and 9 (carry OR NOT bit) replace the carry with the stated function of the carry and the addressed bit. The addressed bit is left unchanged.
- R2: The codes 0, 1 and 2 clear, set and complement the carry. The codes 3, 4 and 5 clear, set and complement the addressed bit and leave every other bit of its byte unchanged.
- R3: Code 10 copies the addressed bit into the carry. Code 11 copies the carry into the addressed bit.
- R4: Code 17 (exclusive OR) and the codes 18 to 31 raise `illegal` with `done`. The carry does not change, no bit is written and `taken` stays low.
- R5: A bit address below 80h selects byte 20h plus address bits 6:3. An address of 80h or above selects the byte equal to the address with bits 2:0 cleared. In both cases bits 2:0 pick the bit within the byte.
- R6: Bit address D7h is the carry. Reads at that address return the carry and writes to it update the carry, and the memory port is not written.
- R7: The branch codes are 12 (taken if carry is 1), 13 (taken if carry is 0), 14 (taken if bit is 1) and 15 (taken if bit is 0). When the branch is not taken, `pc_out` equals `next_pc`.
- R8: Code 16 branches when the addressed bit is 1 and clears that bit in the same operation. When the bit is 0 it does not branch and writes nothing.
- R9: A taken branch gives `pc_out` = `next_pc` + the sign-extended `rel_off`, modulo 2^16. This covers displacements from -128 to +127.
- R10: `done` rises 1 cycle after `start` for codes 0 to 5, 10 and the illegal codes, and 2 cycles after for all other codes. `cycles` holds that count from the cycle after `start`.
- R11: A `start` that arrives while an operation is in progress is ignored.
- R12: `bus_we` and `taken` are only ever high in a `done` cycle, and `done` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, one cycle |
| op | input | 5 | Decoded operation code |
| bit_addr | input | 8 | Direct bit address |
| rel_off | input | 8 | Signed branch displacement |
| next_pc | input | 16 | Address of the next instruction |
| done | output | 1 | Completion pulse |
| taken | output | 1 | Branch taken, valid with done |
| illegal | output | 1 | Rejected operation, valid with done |
| carry | output | 1 | Carry flag |
| cycles | output | 2 | Machine cycles of the current operation |
| pc_out | output | 16 | Resulting program counter, valid with done |
| bus_addr | output | 8 | Byte address of the selected bit |
| bus_bit | output | 3 | Bit position within that byte |
| bus_we | output | 1 | Bit write strobe |
| bus_wdata | output | 1 | Bit write value |
| bus_rdata | input | 1 | Bit read value, combinational from memory |

## Verification
The bench drives inputs on falling edges and counts falling edges from the `start` strobe until `done` is seen. That count must equal the operation's machine-cycle cost plus one: 2 for single-cycle codes and 3 for two-cycle codes. The carry, `taken`, `illegal` and `pc_out` are sampled on that same falling edge, since all of them are registered at the edge that raises `done`. Bit write-backs are checked one falling edge later, after the memory model has taken the write at the edge that ends the `done` cycle. The rule that `bus_we` and `taken` appear only with `done` is watched on every falling edge.

// File: rtl/bool_unit.sv
module bool_unit #(
  parameter int PC_W = 16,
  parameter logic [7:0] CY_ADDR = 8'hD7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [4:0]      op,
  input  logic [7:0]      bit_addr,
  input  logic [7:0]      rel_off,
  input  logic [PC_W-1:0] next_pc,
  output logic            done,
  output logic            taken,
  output logic            illegal,
  output logic            carry,
  output logic [1:0]      cycles,
  output logic [PC_W-1:0] pc_out,
  output logic [7:0]      bus_addr,
  output logic [2:0]      bus_bit,
  output logic            bus_we,
  output logic            bus_wdata,
  input  logic            bus_rdata
);
  localparam logic [4:0] C_CLR = 5'd0,  C_SET = 5'd1,  C_CPL = 5'd2;
  localparam logic [4:0] B_CLR = 5'd3,  B_SET = 5'd4,  B_CPL = 5'd5;
  localparam logic [4:0] L_AND = 5'd6,  L_ANDN = 5'd7, L_OR = 5'd8, L_ORN = 5'd9;
  localparam logic [4:0] M_CB  = 5'd10, M_BC = 5'd11;
  localparam logic [4:0] J_C   = 5'd12, J_NC = 5'd13, J_B = 5'd14, J_NB = 5'd15, J_BC = 5'd16;

  logic [4:0]      op_q;
  logic [7:0]      ba_q, off_q;
  logic [PC_W-1:0] npc_q;
  logic [1:0]      cnt;
  logic            c_nx, w_en, w_val, tk, bad;

  function automatic logic [1:0] cost(input logic [4:0] o);
    if (o <= B_CPL || o == M_CB || o > J_BC) cost = 2'd1;
    else cost = 2'd2;
  endfunction

  wire idle  = (cnt == 2'd0);
  wire fin   = !idle && (cnt == cycles);
  wire alias_hit = (ba_q == CY_ADDR);
  wire rbit  = alias_hit ? carry : bus_rdata;
  wire [PC_W-1:0] target = npc_q + {{(PC_W-8){off_q[7]}}, off_q};

  assign bus_addr = ba_q[7] ? {ba_q[7:3], 3'b000} : (8'h20 + {4'b0000, ba_q[6:3]});
  assign bus_bit  = ba_q[2:0];

  always_comb begin
    c_nx  = carry;
    w_en  = 1'b0;
    w_val = 1'b0;
    tk    = 1'b0;
    bad   = 1'b0;
    case (op_q)
      C_CLR:  c_nx = 1'b0;
      C_SET:  c_nx = 1'b1;
      C_CPL:  c_nx = ~carry;
      B_CLR:  begin w_en = 1'b1; w_val = 1'b0; end
      B_SET:  begin w_en = 1'b1; w_val = 1'b1; end
      B_CPL:  begin w_en = 1'b1; w_val = ~rbit; end
      L_AND:  c_nx = carry & rbit;
      L_ANDN: c_nx = carry & ~rbit;
      L_OR:   c_nx = carry | rbit;
      L_ORN:  c_nx = carry | ~rbit;
      M_CB:   c_nx = rbit;
      M_BC:   begin w_en = 1'b1; w_val = carry; end
      J_C:    tk = carry;
      J_NC:   tk = ~carry;
      J_B:    tk = rbit;
      J_NB:   tk = ~rbit;
      J_BC:   begin tk = rbit; w_en = rbit; w_val = 1'b0; end
      default: bad = 1'b1;
    endcase
    if (w_en && alias_hit) c_nx = w_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= 2'd0;
      op_q      <= 5'd0;
      ba_q      <= 8'd0;
      off_q     <= 8'd0;
      npc_q     <= '0;
      cycles    <= 2'd0;
      done      <= 1'b0;
      taken     <= 1'b0;
      illegal   <= 1'b0;
      carry     <= 1'b0;
      pc_out    <= '0;
      bus_we    <= 1'b0;
      bus_wdata <= 1'b0;
    end else begin
      done    <= 1'b0;
      taken   <= 1'b0;
      illegal <= 1'b0;
      bus_we  <= 1'b0;
      if (idle) begin
        if (start) begin
          op_q   <= op;
          ba_q   <= bit_addr;
          off_q  <= rel_off;
          npc_q  <= next_pc;
          cycles <= cost(op);
          cnt    <= 2'd1;
        end
      end else if (fin) begin
        cnt       <= 2'd0;
        done      <= 1'b1;
        carry     <= c_nx;
        taken     <= tk;
        illegal   <= bad;
        pc_out    <= tk ? target : npc_q;
        bus_we    <= w_en && !alias_hit;
        bus_wdata <= w_val;
      end else begin
        cnt <= cnt + 2'd1;
      end
    end
  end
endmodule

module bool_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       taken,
  input logic       illegal,
  input logic       carry,
  input logic [7:0] bus_addr,
  input logic [2:0] bus_bit,
  input logic       bus_we
);
  // R12
  we_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_we |-> done);
  // R12
  taken_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n) taken |-> done);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R4
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!taken && !bus_we && carry == $past(carry)));
  // R6
  carry_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> !(bus_addr == 8'hD0 && bus_bit == 3'd7));
  // R5
  ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_addr[7]) |-> bus_addr[7:4] == 4'h2);
endmodule

bind bool_unit bool_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .taken(taken), .illegal(illegal),
  .carry(carry), .bus_addr(bus_addr), .bus_bit(bus_bit), .bus_we(bus_we)
);

// File: tb/tb_bool_unit.sv
module tb_bool_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  bit_addr = '0;
  logic [7:0]  rel_off = '0;
  logic [15:0] next_pc = '0;
  logic        done, taken, illegal, carry, bus_we, bus_wdata, bus_rdata;
  logic [1:0]  cycles;
  logic [15:0] pc_out;
  logic [7:0]  bus_addr;
  logic [2:0]  bus_bit;
  logic [7:0]  mem [256];

  int checks = 0;
  int errors = 0;
  logic        r_taken, r_ill;
  logic [15:0] r_pc;
  int          r_lat, r_cyc;

  always #2 clk = ~clk;

  bool_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_addr(bit_addr),
    .rel_off(rel_off), .next_pc(next_pc), .done(done), .taken(taken),
    .illegal(illegal), .carry(carry), .cycles(cycles), .pc_out(pc_out),
    .bus_addr(bus_addr), .bus_bit(bus_bit), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  assign bus_rdata = mem[bus_addr][bus_bit];
  always @(posedge clk) if (bus_we) mem[bus_addr][bus_bit] <= bus_wdata;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R12 monitor
  always @(negedge clk) if (rst_n && ((bus_we && !done) || (taken && !done))) begin
    errors++;
    $display("FAIL R12: we=%0b taken=%0b done=%0b expected strobes only with done", bus_we, taken, done);
  end

  task automatic run(input logic [4:0] o, input logic [7:0] a, input logic [7:0] off, input logic [15:0] npc);
    bit got = 0;
    op = o; bit_addr = a; rel_off = off; next_pc = npc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_lat = -1;
    for (int i = 1; i <= 6; i++) begin
      if (!got) begin
        if (done) begin
          got = 1; r_lat = i - 1;
          r_taken = taken; r_ill = illegal; r_pc = pc_out; r_cyc = int'(cycles);
        end else @(negedge clk);
      end
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 reset done", int'(done), 0);
    chk("R12 reset we", int'(bus_we), 0);
    chk("R2 reset carry", int'(carry), 0);
    chk("R7 reset taken", int'(taken), 0);
  endtask

  task automatic t_carry_ops;
    run(5'd1, 8'h00, 8'h00, 16'h0);
    chk("R2 set carry", int'(carry), 1);
    chk("R10 set carry latency", r_lat, 1);
    chk("R10 cycles one", r_cyc, 1);
    run(5'd2, 8'h00, 8'h00, 16'h0);
    chk("R2 cpl carry", int'(carry), 0);
    run(5'd2, 8'h00, 8'h00, 16'h0);
    chk("R2 cpl carry again", int'(carry), 1);
    run(5'd0, 8'h00, 8'h00, 16'h0);
    chk("R2 clr carry", int'(carry), 0);
  endtask

  task automatic t_logic;
    mem[8'h20] = 8'b0000_0010;
    run(5'd1, 8'h00, 8'h00, 16'h0);
    run(5'd6, 8'h01, 8'h00, 16'h0);
    chk("R1 and 1&1", int'(carry), 1);
    chk("R10 and latency", r_lat, 2);
    chk("R10 cycles two", r_cyc, 2);
    run(5'd6, 8'h00, 8'h00, 16'h0);
    chk("R1 and 1&0", int'(carry), 0);
    run(5'd9, 8'h01, 8'h00, 16'h0);
    chk("R1 orn 0|~1", int'(carry), 0);
    run(5'd8, 8'h01, 8'h00, 16'h0);
    chk("R1 or 0|1", int'(carry), 1);
    run(5'd7, 8'h01, 8'h00, 16'h0);
    chk("R1 andn 1&~1", int'(carry), 0);
    run(5'd9, 8'h00, 8'h00, 16'h0);
    chk("R1 orn 0|~0", int'(carry), 1);
    run(5'd7, 8'h00, 8'h00, 16'h0);
    chk("R1 andn 1&~0", int'(carry), 1);
    chk("R1 source untouched", int'(mem[8'h20]), 2);
  endtask

  task automatic t_bit_ops;
    mem[8'h26] = 8'h00;
    run(5'd4, 8'h35, 8'h00, 16'h0);
    chk("R5 ram set 35h", int'(mem[8'h26]), 8'h20);
    chk("R10 setb latency", r_lat, 1);
    run(5'd5, 8'h30, 8'h00, 16'h0);
    chk("R2 cpl bit 30h", int'(mem[8'h26]), 8'h21);
    run(5'd3, 8'h35, 8'h00, 16'h0);
    chk("R2 clr bit 35h", int'(mem[8'h26]), 8'h01);
    mem[8'h90] = 8'hFF;
    run(5'd3, 8'h92, 8'h00, 16'h0);
    chk("R5 sfr clr 92h", int'(mem[8'h90]), 8'hFB);
    mem[8'h2F] = 8'h00;
    run(5'd4, 8'h7F, 8'h00, 16'h0);
    chk("R5 ram top 7Fh", int'(mem[8'h2F]), 8'h80);
  endtask

  task automatic t_moves;
    mem[8'h88] = 8'h08;
    run(5'd0, 8'h00, 8'h00, 16'h0);
    run(5'd10, 8'h8B, 8'h00, 16'h0);
    chk("R3 mov c,bit", int'(carry), 1);
    chk("R10 mov c,bit latency", r_lat, 1);
    mem[8'h21] = 8'h00;
    run(5'd11, 8'h0E, 8'h00, 16'h0);
    chk("R3 mov bit,c", int'(mem[8'h21]), 8'h40);
    chk("R10 mov bit,c latency", r_lat, 2);
  endtask

  task automatic t_alias;
    mem[8'hD0] = 8'h00;
    run(5'd0, 8'h00, 8'h00, 16'h0);
    run(5'd4, 8'hD7, 8'h00, 16'h0);
    chk("R6 setb D7h carry", int'(carry), 1);
    chk("R6 setb D7h mem", int'(mem[8'hD0]), 0);
    run(5'd5, 8'hD7, 8'h00, 16'h0);
    chk("R6 cpl D7h carry", int'(carry), 0);
    run(5'd1, 8'h00, 8'h00, 16'h0);
    run(5'd10, 8'hD7, 8'h00, 16'h0);
    chk("R6 read D7h", int'(carry), 1);
    run(5'd14, 8'hD7, 8'h10, 16'h0100);
    chk("R6 jb D7h taken", int'(r_taken), 1);
    chk("R6 mem untouched", int'(mem[8'hD0]), 0);
  endtask

  task automatic t_branches;
    mem[8'h22] = 8'h01;
    run(5'd1, 8'h00, 8'h00, 16'h0);
    run(5'd12, 8'h00, 8'h05, 16'h1000);
    chk("R7 jc taken", int'(r_taken), 1);
    chk("R9 jc target", int'(r_pc), 16'h1005);
    chk("R10 branch latency", r_lat, 2);
    run(5'd13, 8'h00, 8'h05, 16'h1000);
    chk("R7 jnc not taken", int'(r_taken), 0);
    chk("R7 jnc pc next", int'(r_pc), 16'h1000);
    run(5'd14, 8'h10, 8'hFE, 16'h2000);
    chk("R7 jb taken", int'(r_taken), 1);
    chk("R9 jb back", int'(r_pc), 16'h1FFE);
    run(5'd15, 8'h10, 8'hFE, 16'h2000);
    chk("R7 jnb not taken", int'(r_taken), 0);
    run(5'd15, 8'h11, 8'h03, 16'h2000);
    chk("R7 jnb taken", int'(r_taken), 1);
    run(5'd0, 8'h00, 8'h00, 16'h0);
    run(5'd13, 8'h00, 8'h04, 16'h0300);
    chk("R7 jnc taken", int'(r_pc), 16'h0304);
  endtask

  task automatic t_jbc;
    mem[8'h24] = 8'h0C;
    run(5'd16, 8'h23, 8'h10, 16'h0400);
    chk("R8 jbc set taken", int'(r_taken), 1);
    chk("R8 jbc target", int'(r_pc), 16'h0410);
    chk("R8 jbc cleared", int'(mem[8'h24]), 8'h04);
    run(5'd16, 8'h23, 8'h10, 16'h0400);
    chk("R8 jbc clear not taken", int'(r_taken), 0);
    chk("R8 jbc clear unchanged", int'(mem[8'h24]), 8'h04);
  endtask

  task automatic t_offsets;
    run(5'd1, 8'h00, 8'h00, 16'h0);
    run(5'd12, 8'h00, 8'h7F, 16'h0100);
    chk("R9 plus 127", int'(r_pc), 16'h017F);
    run(5'd12, 8'h00, 8'h80, 16'h0100);
    chk("R9 minus 128", int'(r_pc), 16'h0080);
    run(5'd12, 8'h00, 8'h20, 16'hFFF0);
    chk("R9 wrap up", int'(r_pc), 16'h0010);
    run(5'd12, 8'h00, 8'h80, 16'h0005);
    chk("R9 wrap down", int'(r_pc), 16'hFF85);
  endtask

  task automatic t_illegal;
    mem[8'h20] = 8'h00;
    run(5'd1, 8'h00, 8'h00, 16'h0);
    run(5'd17, 8'h00, 8'h10, 16'h0500);
    chk("R4 xor illegal", int'(r_ill), 1);
    chk("R4 xor carry kept", int'(carry), 1);
    chk("R4 xor not taken", int'(r_taken), 0);
    chk("R4 xor latency", r_lat, 1);
    run(5'd25, 8'h00, 8'h10, 16'h0500);
    chk("R4 code 25 illegal", int'(r_ill), 1);
    chk("R4 code 25 mem", int'(mem[8'h20]), 0);
    run(5'd6, 8'h00, 8'h00, 16'h0);
    chk("R4 legal op clears flag", int'(r_ill), 0);
  endtask

  task automatic t_busy;
    int extra = 0;
    mem[8'h20] = 8'h00;
    run(5'd1, 8'h00, 8'h00, 16'h0);
    op = 5'd6; bit_addr = 8'h00; start = 1'b1;
    @(negedge clk);
    op = 5'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R11 first op done", int'(done), 1);
    chk("R11 first op result", int'(carry), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R11 second start ignored", extra, 0);
    chk("R11 carry still", int'(carry), 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_carry_ops();
    t_logic();
    t_bit_ops();
    t_moves();
    t_alias();
    t_branches();
    t_jbc();
    t_offsets();
    t_illegal();
    t_busy();
    checks++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule